// File: doc/BRIEF.md
# Receive Overflow Recovery Sequencer

A hardware state machine that runs the mandatory recovery procedure after an Ethernet controller's receive ring overflows, so that driver software does not have to. When the overwrite-warning interrupt is seen, a one-cycle pulse on `ovw_seen` starts it. It then masters the controller's register bus and walks through the procedure. First it records whether a transmit was pending and stops the controller. It waits out any frame still on the wire for a fixed guard time, clears the remote byte counts, decides whether a transmit was lost, and enters internal loopback. Finally it restarts the controller.

Once the controller is running again in loopback, the sequencer hands off to an external packet-drain agent through a `drain_req`/`drain_done` handshake. After the drain completes, it clears the overwrite-warning status bit, takes the controller out of loopback, and reissues the transmit command if the pending frame was never reported as sent or failed. The guard wait is derived from the clock frequency parameter as 1.5 ms worth of cycles (`GUARD = CLK_KHZ*3/2`).

Top module: `ovf_recovery_seq`

## Requirements
- R1: Out of reset and whenever idle, `bus_req`, `drain_req` and `busy` are all low.
- R2: A pulse on `ovw_seen` while idle raises `busy` on the next cycle, and the first bus transaction is a read of the command register. Pulses on `ovw_seen` while `busy` is high are ignored.
- R3: The sequencer captures bit 2 (transmit pending) of the command register read, then writes 0x21 to the command register.
- R4: After the stop write is accepted, exactly `GUARD` cycles pass with no bus request. No status register is polled during this time.
- R5: After the guard wait, 0x00 is written to the low remote byte count register and then to the high one.
- R6: If the captured pending bit is 1, the interrupt status register is read, and a resend is needed only when its bit 1 (transmitted) and bit 3 (transmit error) are both 0. If the pending bit is 0, no status read takes place and no resend is needed.
- R7: The transmit configuration register is then written with `TCR_RUN` with bits 2:1 forced to 01 (loopback). After that, 0x22 is written to the command register.
- R8: `drain_req` rises only after the 0x22 write is accepted. It stays high until `drain_done` is sampled high, and no bus request is made while it is high.
- R9: After the drain, 0x10 is written to the interrupt status register, which clears its bit 4 because writing a one clears that bit. Then `TCR_RUN` (bits 2:1 equal to 00) is written to the transmit configuration register.
- R10: If a resend is needed, 0x26 is written to the command register as the last transaction. The sequence then returns to idle with `busy` low and makes no further transactions.
- R11: A bus request holds `bus_we`, `bus_addr` and `bus_wdata` steady until `bus_ack` is sampled high. Read data is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovw_seen | input | 1 | Start pulse on overwrite-warning interrupt |
| busy | output | 1 | Recovery sequence in progress |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register offset |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transaction accepted this cycle |
| drain_req | output | 1 | Request to external packet drain |
| drain_done | input | 1 | Drain finished pulse |

## Verification
The bench sweeps all eight combinations of the pending, transmitted and transmit-error bits against several bus and drain latencies. It compares the full transaction log with a sequence it builds from those bits. A design that read the wrong status bits, or ignored the pending bit, would either drop the 0x26 reissue and lose a frame, or send a duplicate. The bench also measures the idle gap after the stop command exactly, which catches a design that shortens the wait and touches the controller while a frame is still in flight. It fires a second start pulse in mid-sequence and watches the drain window for bus traffic, which catches a design that restarts itself or removes packets before the controller is running again.

// File: rtl/ovf_recovery_seq.sv
module ovf_recovery_seq #(
  parameter int CLK_KHZ = 200000,
  parameter int AW = 4,
  parameter logic [AW-1:0] CMD_ADDR  = 4'h0,
  parameter logic [AW-1:0] ISR_ADDR  = 4'h7,
  parameter logic [AW-1:0] RBC0_ADDR = 4'hA,
  parameter logic [AW-1:0] RBC1_ADDR = 4'hB,
  parameter logic [AW-1:0] TCR_ADDR  = 4'hD,
  parameter logic [7:0]    TCR_RUN   = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ovw_seen,
  output logic          busy,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  input  logic          bus_ack,
  output logic          drain_req,
  input  logic          drain_done
);
  localparam int GUARD = (CLK_KHZ * 3 / 2 < 1) ? 1 : CLK_KHZ * 3 / 2;
  localparam int CW = $clog2(GUARD + 1);
  localparam logic [CW-1:0] LAST = CW'(GUARD - 1);
  localparam logic [7:0] PEND_MASK = 8'h04;
  localparam logic [7:0] DONE_MASK = 8'h0A;
  localparam logic [7:0] OVW_MASK  = 8'h10;
  localparam logic [7:0] TCR_LOOP  = (TCR_RUN & 8'hF9) | 8'h02;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CMD, S_STOP, S_WAIT, S_RBC0, S_RBC1, S_RD_ISR,
    S_LOOP, S_START, S_DRAIN, S_CLR_OVW, S_UNLOOP, S_RESEND
  } st_t;

  st_t st;
  logic pend, resend;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pend   <= 1'b0;
      resend <= 1'b0;
      cnt    <= '0;
    end else begin
      case (st)
        S_IDLE:    if (ovw_seen) st <= S_RD_CMD;
        S_RD_CMD:  if (bus_ack) begin
                     pend <= |(bus_rdata & PEND_MASK);
                     st   <= S_STOP;
                   end
        S_STOP:    if (bus_ack) begin
                     cnt <= '0;
                     st  <= S_WAIT;
                   end
        S_WAIT:    if (cnt == LAST) st <= S_RBC0;
                   else cnt <= cnt + 1'b1;
        S_RBC0:    if (bus_ack) st <= S_RBC1;
        S_RBC1:    if (bus_ack) begin
                     if (pend) st <= S_RD_ISR;
                     else begin
                       resend <= 1'b0;
                       st     <= S_LOOP;
                     end
                   end
        S_RD_ISR:  if (bus_ack) begin
                     resend <= ~|(bus_rdata & DONE_MASK);
                     st     <= S_LOOP;
                   end
        S_LOOP:    if (bus_ack) st <= S_START;
        S_START:   if (bus_ack) st <= S_DRAIN;
        S_DRAIN:   if (drain_done) st <= S_CLR_OVW;
        S_CLR_OVW: if (bus_ack) st <= S_UNLOOP;
        S_UNLOOP:  if (bus_ack) st <= resend ? S_RESEND : S_IDLE;
        S_RESEND:  if (bus_ack) begin
                     resend <= 1'b0;
                     st     <= S_IDLE;
                   end
        default:   st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign drain_req = (st == S_DRAIN);
  assign bus_req   = busy && (st != S_WAIT) && (st != S_DRAIN);

  always_comb begin
    bus_we    = 1'b1;
    bus_addr  = CMD_ADDR;
    bus_wdata = 8'h00;
    case (st)
      S_RD_CMD:  bus_we = 1'b0;
      S_STOP:    bus_wdata = 8'h21;
      S_RBC0:    bus_addr = RBC0_ADDR;
      S_RBC1:    bus_addr = RBC1_ADDR;
      S_RD_ISR:  begin bus_we = 1'b0; bus_addr = ISR_ADDR; end
      S_LOOP:    begin bus_addr = TCR_ADDR; bus_wdata = TCR_LOOP; end
      S_START:   bus_wdata = 8'h22;
      S_CLR_OVW: begin bus_addr = ISR_ADDR; bus_wdata = OVW_MASK; end
      S_UNLOOP:  begin bus_addr = TCR_ADDR; bus_wdata = TCR_RUN; end
      S_RESEND:  bus_wdata = 8'h26;
      default:   bus_we = 1'b0;
    endcase
  end
endmodule

// File: rtl/ovf_recovery_seq_chk.sv
module ovf_recovery_seq_chk #(
  parameter int CLK_KHZ = 200000,
  parameter int AW = 4,
  parameter logic [AW-1:0] CMD_ADDR = 4'h0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          bus_ack,
  input logic          drain_req,
  input logic          drain_done
);
  localparam int GUARD = (CLK_KHZ * 3 / 2 < 1) ? 1 : CLK_KHZ * 3 / 2;
  localparam int CW = $clog2(GUARD + 1);

  logic [CW-1:0] gap;
  logic stop_acc, start_acc;
  assign stop_acc  = bus_req && bus_ack && bus_we && bus_addr == CMD_ADDR && bus_wdata == 8'h21;
  assign start_acc = bus_req && bus_ack && bus_we && bus_addr == CMD_ADDR && bus_wdata == 8'h22;

  always_ff @(posedge clk) begin
    if (!rst_n) gap <= '0;
    else if (stop_acc) gap <= CW'(GUARD);
    else if (gap != '0) gap <= gap - 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req && !drain_req); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)); // R11
  AST_GUARD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    gap != '0 |-> !bus_req); // R4
  AST_DRAIN_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req |-> !bus_req); // R8
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req && !drain_done |=> drain_req); // R8
  AST_DRAIN_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drain_req) |-> $past(start_acc)); // R7
endmodule

bind ovf_recovery_seq ovf_recovery_seq_chk #(.CLK_KHZ(CLK_KHZ), .AW(AW), .CMD_ADDR(CMD_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .drain_req(drain_req), .drain_done(drain_done));

// File: tb/sim_ovf_recovery_seq.sv
`timescale 1ns/1ps
module sim_ovf_recovery_seq;
  localparam int CLK_KHZ = 20;
  localparam int GUARD = CLK_KHZ * 3 / 2;
  localparam int AW = 4;
  localparam logic [3:0] A_CMD = 4'h0, A_ISR = 4'h7, A_RB0 = 4'hA, A_RB1 = 4'hB, A_TCR = 4'hD;
  localparam logic [7:0] TRUN = 8'h61;
  localparam logic [7:0] TLOOP = (TRUN & 8'hF9) | 8'h02;

  logic clk = 0, rst_n = 0, ovw_seen = 0;
  logic busy, bus_req, bus_we, drain_req;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata = 0;
  logic bus_ack = 0, drain_done = 0;

  always #2.5 clk = ~clk;

  ovf_recovery_seq #(.CLK_KHZ(CLK_KHZ), .AW(AW), .TCR_RUN(TRUN)) u0 (
    .clk(clk), .rst_n(rst_n), .ovw_seen(ovw_seen), .busy(busy),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .drain_req(drain_req), .drain_done(drain_done));

  int checks = 0, fails = 0, cyc = 0;
  int lat = 0, dlat = 0, wcnt = 0, dcnt = 0;
  logic [7:0] cmd_rd = 0, isr_rd = 0;
  logic l_we [0:31]; logic [3:0] l_addr [0:31]; logic [7:0] l_dat [0:31];
  int log_n = 0, drain_at = -1, drain_bus_err = 0;
  int gap = 0, gap_res = -1; bit gap_open = 0;
  logic e_we [0:15]; logic [3:0] e_addr [0:15]; logic [7:0] e_dat [0:15]; string e_tag [0:15];
  int e_n = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic finish_tb();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (gap_open) begin
        if (bus_req) begin gap_open = 0; gap_res = gap; end
        else gap++;
      end
      if (drain_req && bus_req) drain_bus_err++;
      if (bus_ack) begin bus_ack = 0; wcnt = 0; end
      else if (bus_req) begin
        if (wcnt == lat) begin
          bus_ack = 1;
          bus_rdata = (bus_addr == A_CMD) ? cmd_rd : (bus_addr == A_ISR) ? isr_rd : 8'h00;
          if (log_n < 32) begin
            l_we[log_n] = bus_we; l_addr[log_n] = bus_addr; l_dat[log_n] = bus_wdata;
          end
          log_n++;
          if (bus_we && bus_addr == A_CMD && bus_wdata == 8'h21) begin gap_open = 1; gap = 0; end
        end else wcnt++;
      end
      if (drain_done) begin drain_done = 0; dcnt = 0; end
      else if (drain_req) begin
        if (drain_at < 0) drain_at = log_n;
        if (dcnt == dlat) drain_done = 1; else dcnt++;
      end
    end
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_tb();
  end

  task automatic push(input logic we, input logic [3:0] a, input logic [7:0] d, input string t);
    e_we[e_n] = we; e_addr[e_n] = a; e_dat[e_n] = d; e_tag[e_n] = t; e_n++;
  endtask

  task automatic run(input bit txp, input bit ptx, input bit txe, input int l, input int dl, input bit extra);
    int start_idx;
    bit resend;
    lat = l; dlat = dl;
    cmd_rd = 8'h22 | {5'b0, txp, 2'b00};
    isr_rd = 8'h15 | {4'b0, txe, 1'b0, ptx, 1'b0};
    log_n = 0; drain_at = -1; drain_bus_err = 0; gap_res = -1; gap_open = 0;
    resend = txp && !ptx && !txe;
    e_n = 0;
    push(0, A_CMD, 8'h00, "R3");
    push(1, A_CMD, 8'h21, "R3");
    push(1, A_RB0, 8'h00, "R5");
    push(1, A_RB1, 8'h00, "R5");
    if (txp) push(0, A_ISR, 8'h00, "R6");
    push(1, A_TCR, TLOOP, "R7");
    push(1, A_CMD, 8'h22, "R7");
    start_idx = e_n;
    push(1, A_ISR, 8'h10, "R9");
    push(1, A_TCR, TRUN, "R9");
    if (resend) push(1, A_CMD, 8'h26, "R10");

    @(negedge clk); ovw_seen = 1;
    @(negedge clk); ovw_seen = 0;
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
    if (extra) begin
      repeat (GUARD / 2) @(negedge clk);
      ovw_seen = 1; @(negedge clk); ovw_seen = 0;
    end
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    chk(!busy && !bus_req && !drain_req, "R1 idle after sequence", {busy, bus_req, drain_req}, 0);
    repeat (6) @(negedge clk);
    chk(log_n == e_n, extra ? "R2 count with ignored pulse" : "R10 transaction count", log_n, e_n);
    for (int i = 0; i < e_n && i < log_n; i++) begin
      chk(l_we[i] == e_we[i] && l_addr[i] == e_addr[i] && (!e_we[i] || l_dat[i] == e_dat[i]),
          e_tag[i], {l_we[i], 3'b0, l_addr[i], l_dat[i]}, {e_we[i], 3'b0, e_addr[i], e_dat[i]});
    end
    chk(gap_res == GUARD, "R4 guard gap", gap_res, GUARD);
    chk(drain_at == start_idx, "R8 drain after restart", drain_at, start_idx);
    chk(drain_bus_err == 0, "R8 bus quiet in drain", drain_bus_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !bus_req && !drain_req, "R1 reset state", {busy, bus_req, drain_req}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !bus_req && !drain_req, "R1 idle after reset", {busy, bus_req, drain_req}, 0);
    for (int l = 0; l < 3; l++)
      for (int dl = 0; dl < 3; dl++)
        for (int v = 0; v < 8; v++)
          run(v[2], v[1], v[0], l, dl, (v + l + dl) % 3 == 0);
    run(1, 0, 0, 0, 0, 0);
    run(0, 0, 0, 1, 1, 0);
    finish_tb();
  end
endmodule